// File: doc/BRIEF.md
# Processor Performance Monitor Counters

This block gives a processor core four 32-bit event counters and two 32-bit mode-control registers. Software reaches all of them through a special-purpose-register read/write port. On every clock the core presents three event amounts: cycles elapsed, load/store instructions completed and floating-point instructions completed. Each counter adds the amount chosen by its own select field. Every counter has its own select encoding, so one select value can mean different events on different counters.

The block watches the most significant bit of each counter. The first counter has its own overflow interrupt enable. The other three share one common enable. When a watched bit is set and the matching enable is on, the block raises a performance-monitor exception request to the core. The request stays up until the core acknowledges it. Taking the exception, and the freeze and privilege-mode disable fields, are outside this block. Those fields are only stored and read back.

Top module: `perf_mon_ctr`

## Requirements
- R1: After reset, all six registers read zero and the request output is low.
- R2: Register numbers are: control 0 at 952, counter 1 at 953, counter 2 at 954, control 1 at 956, counter 3 at 957 and counter 4 at 958. A write becomes visible on a read in the cycle after the write edge.
- R3: Control 1 keeps only bits [9:0]. The counter 4 select is in [4:0] and the counter 3 select is in [9:5]. Bits [31:10] always read zero.
- R4: Register numbers 936 and 940 read back control 0 and control 1 respectively. Writes to these two numbers change nothing.
- R5: A select value of 1 adds the cycle input to the counter on every clock. This applies to all four counters. The counter 1 select is control 0 [12:6] and the counter 2 select is control 0 [5:0].
- R6: Select value 11 on counter 2 adds the load/store input. Select value 11 on counter 3 adds the floating-point input.
- R7: Select value 0, and any value not listed in R5 or R6, leaves the counter unchanged. This includes value 11 on counters 1 and 4.
- R8: While both control registers are zero, no counter changes except by a write, and no request is raised, even when a counter's bit 31 is set.
- R9: A register write in the same cycle as an increment takes effect, and the increment is lost.
- R10: Counters wrap modulo 2^32.
- R11: The request rises when counter 1 bit 31 is set and control 0 bit 15 is set. The shared enable does not apply to counter 1.
- R12: The request rises when bit 31 of counter 2, 3 or 4 is set and control 0 bit 14 is set. Bit 15 does not apply to these counters.
- R13: The request is sticky. It falls one cycle after an acknowledge pulse, but only if no raising condition still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spr_addr_i | input | 10 | Register number for read and write |
| spr_wdata_i | input | 32 | Write data |
| spr_we_i | input | 1 | Write strobe |
| spr_rdata_o | output | 32 | Read data for spr_addr_i (combinational) |
| evt_cyc_i | input | 8 | Cycles elapsed this clock |
| evt_ldst_i | input | 8 | Loads/stores completed this clock |
| evt_fp_i | input | 8 | Floating-point instructions completed this clock |
| pm_ack_i | input | 1 | Acknowledge pulse that clears the request |
| pm_req_o | output | 1 | Sticky performance-monitor exception request |

## Verification
Reads are combinational, so a write that lands on edge k is visible when the register is read after edge k. A counter increment that samples the event inputs at edge k is also visible after edge k. The request is one register further on: it rises on the edge after the counter value or enable that causes it first appears. It falls on the edge that samples the acknowledge. The bench drives every input at the falling edge and samples outputs there, one settled half-cycle after the edge, and it counts the exact number of rising edges that carry non-zero events.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int SPR_W   = 10;
  localparam int NUM_CNT = 4;
  localparam int SEL_W   = 7;

  localparam logic [SPR_W-1:0] A_CTL0  = 10'd952;
  localparam logic [SPR_W-1:0] A_CNT1  = 10'd953;
  localparam logic [SPR_W-1:0] A_CNT2  = 10'd954;
  localparam logic [SPR_W-1:0] A_CTL1  = 10'd956;
  localparam logic [SPR_W-1:0] A_CNT3  = 10'd957;
  localparam logic [SPR_W-1:0] A_CNT4  = 10'd958;
  localparam logic [SPR_W-1:0] A_UCTL0 = 10'd936;
  localparam logic [SPR_W-1:0] A_UCTL1 = 10'd940;

  localparam logic [SEL_W-1:0] SEL_CYC = 7'd1;
  localparam logic [SEL_W-1:0] SEL_ALT = 7'd11;
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [SPR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic                              we_i,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]    cnt_i,
  output logic [NUM_CNT-1:0]                cnt_we_o,
  output logic [NUM_CNT-1:0][SEL_W-1:0]     sel_o,
  output logic                              en_c1_o,
  output logic                              en_sh_o,
  output logic                              active_o,
  output logic [DATA_W-1:0]                 rdata_o
);
  localparam int C1_W = 10;

  logic [DATA_W-1:0] ctl0_q;
  logic [C1_W-1:0]   ctl1_q;
  logic [DATA_W-1:0] ctl1_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTL0) ctl0_q <= wdata_i;
      if (addr_i == A_CTL1) ctl1_q <= wdata_i[C1_W-1:0];
    end
  end

  assign ctl1_rd = {{(DATA_W-C1_W){1'b0}}, ctl1_q};

  assign cnt_we_o[0] = we_i && (addr_i == A_CNT1);
  assign cnt_we_o[1] = we_i && (addr_i == A_CNT2);
  assign cnt_we_o[2] = we_i && (addr_i == A_CNT3);
  assign cnt_we_o[3] = we_i && (addr_i == A_CNT4);

  // field positions are decoded by the counters, keep them fixed
  assign sel_o[0] = ctl0_q[12:6];
  assign sel_o[1] = {1'b0, ctl0_q[5:0]};
  assign sel_o[2] = {2'b0, ctl1_q[9:5]};
  assign sel_o[3] = {2'b0, ctl1_q[4:0]};
  assign en_sh_o  = ctl0_q[14];
  assign en_c1_o  = ctl0_q[15];
  assign active_o = (ctl0_q != '0) || (ctl1_q != '0);

  always_comb begin
    unique case (addr_i)
      A_CTL0, A_UCTL0: rdata_o = ctl0_q;
      A_CTL1, A_UCTL1: rdata_o = ctl1_rd;
      A_CNT1:          rdata_o = cnt_i[0];
      A_CNT2:          rdata_o = cnt_i[1];
      A_CNT3:          rdata_o = cnt_i[2];
      A_CNT4:          rdata_o = cnt_i[3];
      default:         rdata_o = '0;
    endcase
  end

  a_r4_alias_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_UCTL0 || addr_i == A_UCTL1)) |=> ($stable(ctl0_q) && $stable(ctl1_q)));
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int EVT_W   = 8,
  parameter bit HAS_ALT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [EVT_W-1:0]  cyc_i,
  input  logic [EVT_W-1:0]  alt_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [EVT_W-1:0] inc;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (sel_i == SEL_CYC)                  inc = cyc_i;
    else if (HAS_ALT && sel_i == SEL_ALT)  inc = alt_i;
    else                                   inc = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (we_i)     cnt_q <= wdata_i;
    else if (active_i) cnt_q <= cnt_q + {{(CNT_W-EVT_W){1'b0}}, inc};
  end

  assign cnt_o = cnt_q;

  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cnt_o == $past(wdata_i));
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !we_i) |=> $stable(cnt_o));
  a_r7_sel_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && sel_i == '0) |=> $stable(cnt_o));
endmodule

// File: rtl/pmc_req.sv
module pmc_req
  import pmc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  logic               en_c1_i,
  input  logic               en_sh_i,
  input  logic [NUM_CNT-1:0] msb_i,
  input  logic               ack_i,
  output logic               req_o
);
  logic cond, req_q;

  assign cond = active_i && ((en_c1_i && msb_i[0]) || (en_sh_i && (|msb_i[NUM_CNT-1:1])));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= cond || (req_q && !ack_i);
  end

  assign req_o = req_q;

  a_r13_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
  a_r13_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !cond) |=> !req_o);
  a_r11_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !cond) |=> !req_o);
endmodule

// File: rtl/perf_mon_ctr.sv
module perf_mon_ctr
  import pmc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SPR_W-1:0]  spr_addr_i,
  input  logic [DATA_W-1:0] spr_wdata_i,
  input  logic              spr_we_i,
  output logic [DATA_W-1:0] spr_rdata_o,
  input  logic [EVT_W-1:0]  evt_cyc_i,
  input  logic [EVT_W-1:0]  evt_ldst_i,
  input  logic [EVT_W-1:0]  evt_fp_i,
  input  logic              pm_ack_i,
  output logic              pm_req_o
);
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt;
  logic [NUM_CNT-1:0]             cnt_we;
  logic [NUM_CNT-1:0][SEL_W-1:0]  sel;
  logic [NUM_CNT-1:0][EVT_W-1:0]  alt;
  logic [NUM_CNT-1:0]             msb;
  logic                           en_c1, en_sh, active;

  assign alt[0] = '0;
  assign alt[1] = evt_ldst_i;
  assign alt[2] = evt_fp_i;
  assign alt[3] = '0;

  pmc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (spr_addr_i),
    .wdata_i  (spr_wdata_i),
    .we_i     (spr_we_i),
    .cnt_i    (cnt),
    .cnt_we_o (cnt_we),
    .sel_o    (sel),
    .en_c1_o  (en_c1),
    .en_sh_o  (en_sh),
    .active_o (active),
    .rdata_o  (spr_rdata_o)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmc_counter #(
      .CNT_W   (DATA_W),
      .EVT_W   (EVT_W),
      .HAS_ALT ((i == 1) || (i == 2))
    ) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active),
      .sel_i    (sel[i]),
      .cyc_i    (evt_cyc_i),
      .alt_i    (alt[i]),
      .we_i     (cnt_we[i]),
      .wdata_i  (spr_wdata_i),
      .cnt_o    (cnt[i])
    );
    assign msb[i] = cnt[i][DATA_W-1];
  end

  pmc_req u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .en_c1_i  (en_c1),
    .en_sh_i  (en_sh),
    .msb_i    (msb),
    .ack_i    (pm_ack_i),
    .req_o    (pm_req_o)
  );
endmodule

// File: tb/tb_perf_mon_ctr.sv
module tb_perf_mon_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  cyc = '0, ldst = '0, fp = '0;
  logic        ack = 1'b0;
  logic        req;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  perf_mon_ctr dut (
    .clk_i(clk), .rst_ni(rst_n), .spr_addr_i(addr), .spr_wdata_i(wdata),
    .spr_we_i(we), .spr_rdata_o(rdata), .evt_cyc_i(cyc), .evt_ldst_i(ldst),
    .evt_fp_i(fp), .pm_ack_i(ack), .pm_req_o(req)
  );

  // {write addr, write data, read addr, expected}
  localparam int NV = 9;
  localparam logic [83:0] VEC [NV] = '{
    {10'd952, 32'h5A5A_0000, 10'd952, 32'h5A5A_0000},
    {10'd956, 32'hFFFF_FC00, 10'd956, 32'h0000_0000},
    {10'd953, 32'h1234_5678, 10'd953, 32'h1234_5678},
    {10'd954, 32'h0BAD_F00D, 10'd954, 32'h0BAD_F00D},
    {10'd957, 32'h0000_0001, 10'd957, 32'h0000_0001},
    {10'd958, 32'h7FFF_FFFF, 10'd958, 32'h7FFF_FFFF},
    {10'd936, 32'hFFFF_FFFF, 10'd936, 32'h5A5A_0000},
    {10'd940, 32'h0000_03FF, 10'd956, 32'h0000_0000},
    {10'd940, 32'h0000_03FF, 10'd940, 32'h0000_0000}
  };

  task automatic check(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic run(input int n, input logic [7:0] c, input logic [7:0] l, input logic [7:0] f);
    @(negedge clk); cyc = c; ldst = l; fp = f;
    repeat (n) @(posedge clk);
    @(negedge clk); cyc = '0; ldst = '0; fp = '0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(posedge clk); @(negedge clk); ack = 1'b0;
  endtask

  task automatic clear_cnts();
    wr(10'd953, 0); wr(10'd954, 0); wr(10'd957, 0); wr(10'd958, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (VEC[i]) begin
      rd(VEC[i][41:32], v); check("R1 reset value", v, 32'h0);
    end
    check("R1 request after reset", {31'b0, req}, 0);

    // R2 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][83:74], VEC[i][73:42]);
      rd(VEC[i][41:32], v);
      check("R2/R3/R4 register access", v, VEC[i][31:0]);
    end

    // R5 cycle select on all counters
    wr(10'd952, 0); wr(10'd956, 0); clear_cnts();
    wr(10'd952, 32'h41); wr(10'd956, 32'h21);
    run(4, 3, 5, 7);
    rd(10'd953, v); check("R5 cnt1 cycles", v, 12);
    rd(10'd954, v); check("R5 cnt2 cycles", v, 12);
    rd(10'd957, v); check("R5 cnt3 cycles", v, 12);
    rd(10'd958, v); check("R5 cnt4 cycles", v, 12);

    // R6 R7 alternate events, unlisted selects
    wr(10'd952, 32'h2CB); wr(10'd956, 32'h16B); clear_cnts();
    run(4, 3, 5, 7);
    rd(10'd953, v); check("R7 cnt1 sel 11 holds", v, 0);
    rd(10'd954, v); check("R6 cnt2 load/store", v, 20);
    rd(10'd957, v); check("R6 cnt3 floating point", v, 28);
    rd(10'd958, v); check("R7 cnt4 sel 11 holds", v, 0);

    // R9 write wins over increment
    wr(10'd952, 32'h41); wr(10'd956, 0);
    @(negedge clk); cyc = 8'd3; addr = 10'd953; wdata = 32'd100; we = 1'b1;
    @(posedge clk); @(negedge clk); we = 1'b0; cyc = '0;
    rd(10'd953, v); check("R9 write beats increment", v, 100);

    // R10 wrap
    wr(10'd952, 0); wr(10'd956, 32'h1); wr(10'd958, 32'hFFFF_FFFE);
    run(1, 3, 0, 0);
    rd(10'd958, v); check("R10 wrap", v, 1);

    // R8 idle when both controls zero
    wr(10'd956, 0);
    wr(10'd953, 32'h8000_0000); wr(10'd954, 32'h8000_0000);
    wr(10'd957, 32'h8000_0000); wr(10'd958, 32'h8000_0005);
    run(4, 3, 5, 7);
    rd(10'd958, v); check("R8 no counting while idle", v, 32'h8000_0005);
    check("R8 no request while idle", {31'b0, req}, 0);

    // R11 counter 1 enable
    wr(10'd954, 0); wr(10'd957, 0); wr(10'd958, 0);
    wr(10'd952, 32'h4000); @(negedge clk);
    check("R11 shared enable ignores cnt1", {31'b0, req}, 0);
    wr(10'd952, 32'h8000); @(negedge clk);
    check("R11 cnt1 request", {31'b0, req}, 1);

    // R13 sticky and acknowledge
    pulse_ack();
    check("R13 ack while cause holds", {31'b0, req}, 1);
    wr(10'd952, 32'h0000_0040); @(negedge clk);
    check("R13 sticky after cause gone", {31'b0, req}, 1);
    pulse_ack();
    check("R13 ack clears", {31'b0, req}, 0);

    // R12 shared enable for counters 2-4
    wr(10'd953, 0); wr(10'd957, 32'h8000_0000);
    wr(10'd952, 32'h8000); @(negedge clk);
    check("R12 cnt1 enable ignores cnt3", {31'b0, req}, 0);
    wr(10'd952, 32'h4000); @(negedge clk);
    check("R12 cnt3 request", {31'b0, req}, 1);
    wr(10'd957, 0); wr(10'd952, 0); pulse_ack();
    wr(10'd958, 32'h8000_0000); wr(10'd952, 32'h4000); @(negedge clk);
    check("R12 cnt4 request", {31'b0, req}, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule